// File: doc/BRIEF.md
# Three-Register Swap Sequencer

This block holds three N-bit registers that share one internal data bus and contains the control state machine that exchanges the contents of the first two of them. The third register serves as scratch storage. A single start input launches a fixed three-step choreography. In each step exactly one register drives the bus and exactly one other register captures it. A one-cycle done pulse marks the final step. A multiplexer replaces tri-state bus drivers. When no register drives the bus, the bus carries the external data input.

Before a swap, the registers are preloaded through a valid/ready stream port. A beat carries a data word and a register selector. Ready is high only while the sequencer is idle. A beat is taken on any rising edge where valid and ready are both high. While a swap runs, ready is low and the producer must hold its beat until ready returns. A beat whose selector names no register is accepted and discarded.

Top module: `swap_seq`

## Requirements
- R1: After reset the sequencer is idle. In that state ext_ready is 1, drv_en and ld_en are 0, done is 0 and all three registers read 0.
- R2: While idle with start at 0 and no accepted load beat, the block stays idle: drv_en stays 0 and no register changes.
- R3: If start is 1 at a rising edge while idle, the next cycle is step 1. In step 1, drv_en is 3'b010 (register 2 on the bus) and ld_en is 3'b100 (register 3 loads).
- R4: The steps then follow on consecutive clocks whatever start does. Step 2 has drv_en 3'b001 and ld_en 3'b010. Step 3 has drv_en 3'b100 and ld_en 3'b001. The cycle after step 3 is idle.
- R5: done is 1 only during step 3, so it lasts exactly one cycle per swap.
- R6: When a swap completes, register 1 holds the old value of register 2, register 2 holds the old value of register 1, and register 3 holds the old value of register 2.
- R7: In every cycle at most one bit of drv_en and at most one bit of ld_en is set. When drv_en is 0, bus_q equals ext_data; otherwise bus_q equals the value of the driving register.
- R8: When ext_valid and ext_ready are both 1 at a rising edge, the register chosen by ext_sel takes ext_data. The selector codes are 0 for register 1, 1 for register 2 and 2 for register 3. During that cycle the matching ld_en bit is 1.
- R9: ext_sel code 3 is accepted but loads no register.
- R10: A start pulse during steps 1 to 3 is ignored. The swap neither restarts nor lengthens, and the block is idle in the cycle after step 3.
- R11: ext_ready is 0 during steps 1 to 3. An ext_valid beat offered then changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Begins a swap when sampled high while idle |
| ext_valid | input | 1 | External load beat valid |
| ext_ready | output | 1 | Load port ready; high only when idle |
| ext_sel | input | 2 | Target register of the load beat (3 = none) |
| ext_data | input | N | External data word; also drives the bus when no register does |
| drv_en | output | 3 | Per-register bus-drive enables (bit 0 = register 1) |
| ld_en | output | 3 | Per-register load enables (bit 0 = register 1) |
| done | output | 1 | High during the final transfer step |
| bus_q | output | N | Current value on the shared bus |
| reg1_q | output | N | Register 1 contents |
| reg2_q | output | N | Register 2 contents |
| reg3_q | output | N | Register 3 contents |

## Verification
A wrong state in the controller shows up in drv_en and ld_en in the same cycle, because both decode the present state directly. A skipped or repeated step shows up within one clock as an unexpected enable pattern, or as done arriving at the wrong time. A wrong load target corrupts a register value that appears on the register outputs one edge later. The final register contents therefore expose any wrong step at the end of the swap. Since ext_ready is low exactly when the state is not idle, a stuck or lengthened sequence also shows on the stream port.

// File: rtl/swap_pkg.sv
package swap_pkg;
  localparam int NREG  = 3;
  localparam int SEL_W = $clog2(NREG + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MV1  = 2'd1,
    ST_MV2  = 2'd2,
    ST_MV3  = 2'd3
  } swap_state_e;
endpackage

// File: rtl/swap_ctrl.sv
module swap_ctrl
  import swap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ext_valid,
  input  logic [SEL_W-1:0] ext_sel,
  output logic             idle,
  output logic [NREG-1:0]  drv,
  output logic [NREG-1:0]  ld,
  output logic             done
);
  swap_state_e state_q, state_d;
  logic [NREG-1:0] ext_ld;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_MV1;
      ST_MV1:  state_d = ST_MV2;
      ST_MV2:  state_d = ST_MV3;
      ST_MV3:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // one-hot decode of the external load target; codes past NREG select none
  always_comb begin
    ext_ld = '0;
    for (int i = 0; i < NREG; i++)
      if (ext_sel == SEL_W'(i)) ext_ld[i] = 1'b1;
  end

  always_comb begin
    idle = 1'b0;
    drv  = '0;
    ld   = '0;
    done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        idle = 1'b1;
        if (ext_valid) ld = ext_ld;
      end
      ST_MV1: begin drv = 3'b010; ld = 3'b100; end
      ST_MV2: begin drv = 3'b001; ld = 3'b010; end
      ST_MV3: begin drv = 3'b100; ld = 3'b001; done = 1'b1; end
      default: idle = 1'b1;
    endcase
  end
endmodule

// File: rtl/swap_bus_mux.sv
module swap_bus_mux
  import swap_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [NREG-1:0]         drv,
  input  logic [NREG-1:0][N-1:0]  regs,
  input  logic [N-1:0]            ext_data,
  output logic [N-1:0]            bus
);
  logic [NREG:0][N-1:0] term;

  assign term[NREG] = (drv == '0) ? ext_data : '0;

  for (genvar i = 0; i < NREG; i++) begin : g_term
    assign term[i] = drv[i] ? regs[i] : '0;
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i <= NREG; i++) bus = bus | term[i];
  end
endmodule

// File: rtl/swap_regfile.sv
module swap_regfile
  import swap_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREG-1:0]         ld,
  input  logic [N-1:0]            bus,
  output logic [NREG-1:0][N-1:0]  regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)     regs[i] <= '0;
      else if (ld[i]) regs[i] <= bus;
    end
  end
endmodule

// File: rtl/swap_seq.sv
module swap_seq
  import swap_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ext_valid,
  output logic             ext_ready,
  input  logic [1:0]       ext_sel,
  input  logic [N-1:0]     ext_data,
  output logic [2:0]       drv_en,
  output logic [2:0]       ld_en,
  output logic             done,
  output logic [N-1:0]     bus_q,
  output logic [N-1:0]     reg1_q,
  output logic [N-1:0]     reg2_q,
  output logic [N-1:0]     reg3_q
);
  logic                   idle;
  logic [NREG-1:0]        drv, ld;
  logic [NREG-1:0][N-1:0] regs;
  logic [N-1:0]           bus;

  swap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ext_valid(ext_valid), .ext_sel(ext_sel),
    .idle(idle), .drv(drv), .ld(ld), .done(done)
  );

  swap_bus_mux #(.N(N)) u_mux (
    .drv(drv), .regs(regs), .ext_data(ext_data), .bus(bus)
  );

  swap_regfile #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld(ld), .bus(bus), .regs(regs)
  );

  assign ext_ready = idle;
  assign drv_en    = drv;
  assign ld_en     = ld;
  assign bus_q     = bus;
  assign reg1_q    = regs[0];
  assign reg2_q    = regs[1];
  assign reg3_q    = regs[2];
endmodule

// File: rtl/swap_seq_chk.sv
module swap_seq_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ext_ready,
  input logic [N-1:0] ext_data,
  input logic [2:0]   drv_en,
  input logic [2:0]   ld_en,
  input logic         done,
  input logic [N-1:0] bus_q,
  input logic [N-1:0] reg1_q,
  input logic [N-1:0] reg2_q,
  input logic [N-1:0] reg3_q
);
  // R7: single driver and single loader
  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_en) && $onehot0(ld_en));

  // R7: undriven bus falls back to external data
  p_bus_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en == 3'b000) |-> (bus_q == ext_data));

  // R2: idle holds without start
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ready && !start) |=> ext_ready);

  // R3: start from idle enters step 1
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ready && start) |=> (drv_en == 3'b010 && ld_en == 3'b100 && !done));

  // R4: step ordering
  p_step12_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en == 3'b010) |=> (drv_en == 3'b001 && ld_en == 3'b010));
  p_step23_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en == 3'b001) |=> (drv_en == 3'b100 && ld_en == 3'b001));

  // R5 / R10: done lasts one cycle and is followed by idle
  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ext_ready));

  // R11: ready low exactly while a transfer step drives the bus
  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ready == (drv_en == 3'b000));

  // R6: register 1 captures the bus in the last step
  p_ld1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en[0] |=> (reg1_q == $past(bus_q)));

  // R2: registers stay put without a load enable
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en == 3'b000) |=> (reg1_q == $past(reg1_q) && reg2_q == $past(reg2_q)
                           && reg3_q == $past(reg3_q)));
endmodule

bind swap_seq swap_seq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ext_ready(ext_ready),
  .ext_data(ext_data), .drv_en(drv_en), .ld_en(ld_en), .done(done),
  .bus_q(bus_q), .reg1_q(reg1_q), .reg2_q(reg2_q), .reg3_q(reg3_q)
);

// File: tb/swap_seq_tb.sv
module swap_seq_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         ext_valid = 1'b0;
  logic         ext_ready;
  logic [1:0]   ext_sel = 2'd0;
  logic [N-1:0] ext_data = '0;
  logic [2:0]   drv_en, ld_en;
  logic         done;
  logic [N-1:0] bus_q, reg1_q, reg2_q, reg3_q;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  swap_seq #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_valid(ext_valid),
    .ext_ready(ext_ready), .ext_sel(ext_sel), .ext_data(ext_data),
    .drv_en(drv_en), .ld_en(ld_en), .done(done), .bus_q(bus_q),
    .reg1_q(reg1_q), .reg2_q(reg2_q), .reg3_q(reg3_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check_regs(input string req, input logic [N-1:0] a,
                            input logic [N-1:0] b, input logic [N-1:0] c);
    chk(req, "reg1", reg1_q, a);
    chk(req, "reg2", reg2_q, b);
    chk(req, "reg3", reg3_q, c);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1", "ready", ext_ready, 1);
    chk("R1", "drv_en", drv_en, 0);
    chk("R1", "ld_en", ld_en, 0);
    chk("R1", "done", done, 0);
    check_regs("R1", 0, 0, 0);
  endtask

  task automatic preload(input logic [1:0] sel, input logic [N-1:0] d);
    ext_valid = 1'b1; ext_sel = sel; ext_data = d;
    #1;
    chk("R8", "ready", ext_ready, 1);
    if (sel != 2'd3) chk("R8", "ld_en", ld_en, 3'b001 << sel);
    else             chk("R9", "ld_en", ld_en, 0);
    chk("R7", "bus", bus_q, d);
    step();
    ext_valid = 1'b0;
  endtask

  task automatic t_preload(input logic [N-1:0] a, input logic [N-1:0] b,
                           input logic [N-1:0] c);
    preload(2'd0, a); preload(2'd1, b); preload(2'd2, c);
    check_regs("R8", a, b, c);
  endtask

  task automatic t_sel_none();
    logic [N-1:0] a = reg1_q, b = reg2_q, c = reg3_q;
    preload(2'd3, 8'hEE);
    check_regs("R9", a, b, c);
  endtask

  task automatic t_idle_hold();
    logic [N-1:0] a = reg1_q, b = reg2_q, c = reg3_q;
    ext_data = 8'h5A;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R2", "drv_en", drv_en, 0);
      chk("R2", "ready", ext_ready, 1);
    end
    check_regs("R2", a, b, c);
  endtask

  // mode 0: plain; 1: start pulse mid-swap; 2: load beat offered mid-swap
  task automatic t_swap(input int mode);
    logic [N-1:0] a = reg1_q, b = reg2_q;
    start = 1'b1;
    step();
    start = 1'b0;
    chk("R3", "drv_en", drv_en, 3'b010);
    chk("R3", "ld_en", ld_en, 3'b100);
    chk("R7", "bus", bus_q, b);
    chk("R11", "ready", ext_ready, 0);
    if (mode == 1) start = 1'b1;
    if (mode == 2) begin ext_valid = 1'b1; ext_sel = 2'd0; ext_data = 8'hC3; end
    step();
    chk("R4", "drv_en s2", drv_en, 3'b001);
    chk("R4", "ld_en s2", ld_en, 3'b010);
    chk("R5", "done s2", done, 0);
    chk("R6", "reg3 s2", reg3_q, b);
    if (mode == 2) chk("R11", "reg1 busy", reg1_q, a);
    step();
    chk("R4", "drv_en s3", drv_en, 3'b100);
    chk("R4", "ld_en s3", ld_en, 3'b001);
    chk("R5", "done s3", done, 1);
    chk("R6", "reg2 s3", reg2_q, a);
    start = 1'b0;
    ext_valid = 1'b0;
    step();
    chk("R5", "done after", done, 0);
    chk("R10", "idle after", ext_ready, 1);
    chk("R10", "drv after", drv_en, 0);
    check_regs("R6", b, a, b);
    step();
    chk("R10", "no restart", drv_en, 0);
  endtask

  initial begin
    t_reset();
    t_idle_hold();
    t_preload(8'h11, 8'h22, 8'h33);
    t_sel_none();
    t_swap(0);
    t_preload(8'hA5, 8'h3C, 8'h00);
    t_swap(1);
    t_preload(8'hFF, 8'h01, 8'h7E);
    t_swap(2);
    t_swap(0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule